// File: doc/BRIEF.md
# Fault Diagnosis Rollback Controller

This controller sorts a detected failure into one of three classes by replaying the failing work. When a symptom is reported while it is idle, it records which core was running. It asks the checkpoint logic to roll back and restarts on that same core. If the symptom does not come back within the replay window, the fault was a transient hardware upset or a nondeterministic software bug. If it comes back, the controller rolls back a second time and moves the replay to a neighbouring core. A clean run there points to a permanent defect in the first core. A repeat of the symptom there points to a deterministic software bug.

Checkpoint storage, the cores and the symptom detectors are outside the block. They are modelled only as handshake inputs and outputs. Each rollback request stays asserted until the checkpoint logic acknowledges it. The result appears on a 2-bit class code together with a valid strobe that lasts one cycle. Symptom pulses that arrive while a diagnosis is in progress have no effect on the diagnosis; they are only counted in a saturating counter.

Top module: `fault_diag_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `rollback_req_o` is 0, `class_valid_o` is 0, `class_o` is 00 and `ovf_count_o` is 0.
- R2: A `symptom_i` pulse sampled while idle captures `fault_core_i`. From the next cycle, `rollback_req_o` is 1 and `restart_core_o` equals the captured index.
- R3: `rollback_req_o` stays 1 until `rollback_ack_i` is sampled high. It is 0 in the cycle after the acknowledge.
- R4: If `window_done_i` ends the same-core replay, the next cycle shows `class_valid_o`=1 with `class_o`=01 for exactly one cycle, and the controller is then idle again.
- R5: If `recur_i` ends the same-core replay, a second rollback request follows in the next cycle. During that request and the replay after it, `restart_core_o` equals (captured index + 1) mod `NUM_CORES`.
- R6: If `window_done_i` ends the replay on the other core, the result is `class_o`=10 (permanent defect in the original core).
- R7: If `recur_i` ends the replay on the other core, the result is `class_o`=11 (deterministic software bug).
- R8: If `recur_i` and `window_done_i` are high in the same cycle during a replay, the phase is treated as recurred.
- R9: Each cycle in which `symptom_i` is high while the controller is not idle adds one to `ovf_count_o`. The count saturates at 2^`OVF_W`-1, and these pulses leave the diagnosis outcome unchanged.
- R10: `recur_i`, `window_done_i` and `rollback_ack_i` have no effect while the controller is idle.
- R11: `class_o` is 00 in every cycle where `class_valid_o` is 0.
- R12: When the captured index is `NUM_CORES`-1, the other core is core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| symptom_i | input | 1 | Symptom detected pulse |
| fault_core_i | input | $clog2(NUM_CORES) | Index of the core that raised the symptom |
| recur_i | input | 1 | Symptom seen again during a replay |
| window_done_i | input | 1 | Replay window completed |
| rollback_ack_i | input | 1 | Rollback to last checkpoint finished |
| rollback_req_o | output | 1 | Rollback request, held until acknowledged |
| restart_core_o | output | $clog2(NUM_CORES) | Core on which to restart execution |
| class_o | output | 2 | Classification: 01 transient/nondeterministic, 10 permanent core defect, 11 deterministic software |
| class_valid_o | output | 1 | One-cycle strobe qualifying `class_o` |
| ovf_count_o | output | OVF_W | Saturating count of symptoms ignored during a diagnosis |

## Verification
The assertions assume the checkpoint logic raises `rollback_ack_i` only in reply to a pending request. They also assume `fault_core_i` always holds an index below `NUM_CORES`. The bench raises the acknowledge only after it has seen the request. It drives core indices only from the valid range, and it drives acknowledges, recurrences and window completions while idle only in a separate directed test of R10. Overflow pulses are placed inside the replay windows, so their effect on the outcome can be compared with the table of expected classes.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RB1       = 3'd1,
    ST_REP_SAME  = 3'd2,
    ST_RB2       = 3'd3,
    ST_REP_OTHER = 3'd4,
    ST_REPORT    = 3'd5
  } fdc_state_e;

  localparam logic [1:0] CLS_NONE      = 2'b00;
  localparam logic [1:0] CLS_TRANSIENT = 2'b01;
  localparam logic [1:0] CLS_PERM_CORE = 2'b10;
  localparam logic [1:0] CLS_DET_SW    = 2'b11;
endpackage

// File: rtl/fdc_next_state.sv
module fdc_next_state
  import fdc_pkg::*;
(
  input  fdc_state_e state_q,
  input  logic       symptom_i,
  input  logic       recur_i,
  input  logic       window_done_i,
  input  logic       rollback_ack_i,
  output fdc_state_e state_d,
  output logic       cls_load,
  output logic [1:0] cls_d,
  output logic       capture_core
);
  always_comb begin
    state_d      = state_q;
    cls_load     = 1'b0;
    cls_d        = CLS_NONE;
    capture_core = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (symptom_i) begin
          state_d      = ST_RB1;
          capture_core = 1'b1;
        end
      end
      ST_RB1: begin
        if (rollback_ack_i) state_d = ST_REP_SAME;
      end
      ST_REP_SAME: begin
        // a recurrence takes priority over window completion
        if (recur_i) begin
          state_d = ST_RB2;
        end else if (window_done_i) begin
          state_d  = ST_REPORT;
          cls_load = 1'b1;
          cls_d    = CLS_TRANSIENT;
        end
      end
      ST_RB2: begin
        if (rollback_ack_i) state_d = ST_REP_OTHER;
      end
      ST_REP_OTHER: begin
        if (recur_i) begin
          state_d  = ST_REPORT;
          cls_load = 1'b1;
          cls_d    = CLS_DET_SW;
        end else if (window_done_i) begin
          state_d  = ST_REPORT;
          cls_load = 1'b1;
          cls_d    = CLS_PERM_CORE;
        end
      end
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/fdc_core_sel.sv
module fdc_core_sel #(
  parameter int NUM_CORES = 4,
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CIDX_W-1:0] core_in,
  input  logic              use_other,
  output logic [CIDX_W-1:0] core_out
);
  localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(NUM_CORES - 1);

  logic [CIDX_W-1:0] orig_q;
  logic [CIDX_W-1:0] other_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       orig_q <= '0;
    else if (capture) orig_q <= core_in;
  end

  generate
    if ((1 << CIDX_W) == NUM_CORES) begin : g_pow2
      // natural wrap of the index width gives the modulo
      assign other_idx = orig_q + 1'b1;
    end else begin : g_npow2
      assign other_idx = (orig_q == LAST_IDX) ? '0 : orig_q + 1'b1;
    end
  endgenerate

  assign core_out = use_other ? other_idx : orig_q;
endmodule

// File: rtl/fdc_ovf_cnt.sv
module fdc_ovf_cnt #(
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [OVF_W-1:0] count
);
  logic [OVF_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != {OVF_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/fault_diag_ctrl.sv
module fault_diag_ctrl
  import fdc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int OVF_W     = 8,
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              symptom_i,
  input  logic [CIDX_W-1:0] fault_core_i,
  input  logic              recur_i,
  input  logic              window_done_i,
  input  logic              rollback_ack_i,
  output logic              rollback_req_o,
  output logic [CIDX_W-1:0] restart_core_o,
  output logic [1:0]        class_o,
  output logic              class_valid_o,
  output logic [OVF_W-1:0]  ovf_count_o
);
  fdc_state_e state_q, state_d;
  logic       cls_load;
  logic [1:0] cls_d, cls_q;
  logic       capture_core;
  logic       use_other;

  fdc_next_state u_next (
    .state_q        (state_q),
    .symptom_i      (symptom_i),
    .recur_i        (recur_i),
    .window_done_i  (window_done_i),
    .rollback_ack_i (rollback_ack_i),
    .state_d        (state_d),
    .cls_load       (cls_load),
    .cls_d          (cls_d),
    .capture_core   (capture_core)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cls_q <= CLS_NONE;
    else if (cls_load) cls_q <= cls_d;
  end

  assign use_other = (state_q == ST_RB2) || (state_q == ST_REP_OTHER);

  fdc_core_sel #(.NUM_CORES(NUM_CORES)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture_core),
    .core_in   (fault_core_i),
    .use_other (use_other),
    .core_out  (restart_core_o)
  );

  fdc_ovf_cnt #(.OVF_W(OVF_W)) u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (symptom_i && (state_q != ST_IDLE)),
    .count (ovf_count_o)
  );

  assign rollback_req_o = (state_q == ST_RB1) || (state_q == ST_RB2);
  assign class_valid_o  = (state_q == ST_REPORT);
  assign class_o        = class_valid_o ? cls_q : CLS_NONE;
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
  parameter int NUM_CORES = 4,
  parameter int OVF_W     = 8,
  localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rollback_ack_i,
  input logic              rollback_req_o,
  input logic [CIDX_W-1:0] restart_core_o,
  input logic [1:0]        class_o,
  input logic              class_valid_o,
  input logic [OVF_W-1:0]  ovf_count_o
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_req_o && !rollback_ack_i |=> rollback_req_o);

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_req_o && rollback_ack_i |=> !rollback_req_o);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid_o |=> !class_valid_o);

  assert_class_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !class_valid_o |-> class_o == 2'b00);

  assert_class_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid_o |-> class_o != 2'b00);

  assert_no_req_on_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid_o |-> !rollback_req_o);

  assert_ovf_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_count_o >= $past(ovf_count_o));

  assert_core_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    int'(restart_core_o) < NUM_CORES);
endmodule

bind fault_diag_ctrl fdc_checker #(.NUM_CORES(NUM_CORES), .OVF_W(OVF_W)) u_fdc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rollback_ack_i (rollback_ack_i),
  .rollback_req_o (rollback_req_o),
  .restart_core_o (restart_core_o),
  .class_o        (class_o),
  .class_valid_o  (class_valid_o),
  .ovf_count_o    (ovf_count_o)
);

// File: tb/fault_diag_ctrl_test.sv
module fault_diag_ctrl_test;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int OW = 8;
  localparam int NV = 6;
  // {core[7:6], same-phase end[5:4], other-phase end[3:2], expected class[1:0]}
  // phase end: 0 window done, 1 recurrence, 2 both together
  localparam logic [7:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 2'b01},
    {2'd1, 2'd1, 2'd0, 2'b10},
    {2'd3, 2'd1, 2'd1, 2'b11},
    {2'd2, 2'd2, 2'd0, 2'b10},
    {2'd3, 2'd1, 2'd2, 2'b11},
    {2'd1, 2'd0, 2'd0, 2'b01}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic symptom_i, recur_i, window_done_i, rollback_ack_i;
  logic [CW-1:0] fault_core_i;
  logic rollback_req_o, class_valid_o;
  logic [CW-1:0] restart_core_o;
  logic [1:0] class_o;
  logic [OW-1:0] ovf_count_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_ovf = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  fault_diag_ctrl #(.NUM_CORES(NC), .OVF_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .symptom_i(symptom_i), .fault_core_i(fault_core_i),
    .recur_i(recur_i), .window_done_i(window_done_i), .rollback_ack_i(rollback_ack_i),
    .rollback_req_o(rollback_req_o), .restart_core_o(restart_core_o),
    .class_o(class_o), .class_valid_o(class_valid_o), .ovf_count_o(ovf_count_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic end_phase(input int how);
    window_done_i = (how == 0) || (how == 2);
    recur_i       = (how == 1) || (how == 2);
    tick();
    window_done_i = 1'b0;
    recur_i       = 1'b0;
  endtask

  task automatic ack_now;
    rollback_ack_i = 1'b1;
    tick();
    rollback_ack_i = 1'b0;
  endtask

  task automatic run_vec(input logic [7:0] v);
    int core, alt;
    core = int'(v[7:6]);
    alt  = (core + 1) % NC;
    symptom_i = 1'b1; fault_core_i = v[7:6];
    tick();
    symptom_i = 1'b0; fault_core_i = '0;
    chk("R2 req", int'(rollback_req_o), 1);
    chk("R2 core", int'(restart_core_o), core);
    tick(); tick();
    chk("R3 hold", int'(rollback_req_o), 1);
    ack_now();
    chk("R3 drop", int'(rollback_req_o), 0);
    symptom_i = 1'b1;       // stray symptom during replay, R9
    tick();
    symptom_i = 1'b0;
    exp_ovf = exp_ovf + 1;
    chk("R9 count", int'(ovf_count_o), exp_ovf);
    end_phase(int'(v[5:4]));
    if (v[5:4] == 2'd0) begin
      chk("R4 valid", int'(class_valid_o), 1);
      chk("R4 class", int'(class_o), int'(v[1:0]));
    end else begin
      chk("R5 R8 req2", int'(rollback_req_o), 1);
      chk("R5 R12 alt", int'(restart_core_o), alt);
      ack_now();
      chk("R5 alt replay", int'(restart_core_o), alt);
      end_phase(int'(v[3:2]));
      chk("R6 R7 valid", int'(class_valid_o), 1);
      chk("R6 R7 R8 class", int'(class_o), int'(v[1:0]));
    end
    tick();
    chk("R4 pulse", int'(class_valid_o), 0);
    chk("R11 class", int'(class_o), 0);
    chk("R4 idle", int'(rollback_req_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; symptom_i = 1'b0; recur_i = 1'b0;
    window_done_i = 1'b0; rollback_ack_i = 1'b0; fault_core_i = '0;
    tick();
    chk("R1 req", int'(rollback_req_o), 0);
    chk("R1 valid", int'(class_valid_o), 0);
    chk("R1 ovf", int'(ovf_count_o), 0);
    tick(); rst_n = 1'b1; tick();
    chk("R1 req after", int'(rollback_req_o), 0);
    chk("R1 class after", int'(class_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R10: replay inputs while idle
    rollback_ack_i = 1'b1; recur_i = 1'b1; window_done_i = 1'b1;
    tick();
    rollback_ack_i = 1'b0; recur_i = 1'b0; window_done_i = 1'b0;
    tick();
    chk("R10 req", int'(rollback_req_o), 0);
    chk("R10 valid", int'(class_valid_o), 0);
    chk("R10 ovf", int'(ovf_count_o), exp_ovf);

    // R9 saturation: symptom held while waiting for acknowledge
    symptom_i = 1'b1; fault_core_i = 2'd2;
    tick();
    for (int k = 0; k < 300; k++) tick();
    symptom_i = 1'b0;
    tick();
    chk("R9 saturate", int'(ovf_count_o), 255);
    chk("R9 still waiting", int'(rollback_req_o), 1);
    chk("R9 core kept", int'(restart_core_o), 2);
    ack_now();
    end_phase(0);
    chk("R9 outcome", int'(class_o), 1);
    tick();

    // R1: reset in the middle of a diagnosis
    symptom_i = 1'b1; fault_core_i = 2'd1;
    tick();
    symptom_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid req", int'(rollback_req_o), 0);
    chk("R1 mid ovf", int'(ovf_count_o), 0);
    tick(); rst_n = 1'b1; tick();
    chk("R1 mid idle", int'(class_valid_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule